// File: doc/BRIEF.md
# Descriptor Channel Sequencer

This block is a single-channel engine that walks a program of 32-bit descriptors held in memory. Software loads the address of the first descriptor, writes the enable bit, and the engine then reads one descriptor at a time, decodes its 3-bit opcode and either carries it out itself (event wait, unconditional jump, counted loop) or hands it to an external sub-unit through a one-cycle start pulse and a done strobe (data move, read-modify-write, poll, compare-branch, paced transfer).

Each descriptor can request an interrupt when it completes and can halt the channel after it. Two 16-bit loop counters, a sticky bus-error bit, a single-step (manual) mode and a level interrupt output complete the control set. Memory is reached through a plain request/acknowledge/error read port, so the block can sit in front of any fabric adapter.

Top module: `desc_seq`

## Requirements
- R1: After reset the configuration register (address 1) reads 0x0000_0004 (only the stopped bit 2 set), the descriptor-address register (address 0) and loop register (address 2) read 0, and `irq`, `mem_req` and `sub_start` are low.
- R2: While enabled, the engine reads the descriptor at the descriptor-address register, decodes the opcode from bits 2:0 (0 move, 1 write, 2 wait, 3 jump, 4 loop, 5 poll, 6 branch, 7 transfer), and advances that register by 4 for each word it consumes.
- R3: Opcodes 0, 1, 5, 6 and 7 produce exactly one `sub_start` pulse carrying the opcode on `sub_op` and the whole word on `sub_desc`; the descriptor completes only when `sub_done` is seen.
- R4: A jump (opcode 3) reads the following word and continues fetching from that address.
- R5: A loop (opcode 4) uses bit 5 to pick counter 0 (loop register bits 15:0) or counter 1 (bits 31:16); if that counter is nonzero it is decremented and execution continues at the address in the following word, otherwise the following word is skipped.
- R6: A wait (opcode 2) reads two following words as the low and high halves of a 64-bit mask, uses bit 6 to pick event bank `evt0` (0) or `evt1` (1), and completes in the first cycle in which any masked line of that bank is high.
- R7: A descriptor with bit 3 set sets the interrupt flag (configuration bit 16) on completion; `irq` is the flag ANDed with interrupt enable (bit 17); writing 1 to bit 16 clears the flag.
- R8: A descriptor with bit 4 set halts the channel after it completes: enable (bit 0) is cleared and stopped (bit 2) reads 1.
- R9: With manual (bit 3) set, the channel halts after every descriptor, stopping with enable cleared.
- R10: An error response on the memory port sets bus error (bit 4), clears enable and halts; writing 1 to bit 4 clears it.
- R11: Writes to the descriptor-address and loop registers are ignored while the channel is not stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 descriptor address, 1 configuration, 2 loop counters |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory read request, held until acknowledge or error |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Memory read completed, data valid |
| mem_err | input | 1 | Memory read failed |
| mem_rdata | input | 32 | Memory read data |
| sub_start | output | 1 | One-cycle start pulse to the sub-unit |
| sub_op | output | 3 | Opcode handed to the sub-unit |
| sub_desc | output | 32 | Descriptor word handed to the sub-unit |
| sub_done | input | 1 | Sub-unit completion strobe |
| evt0 | input | 64 | Event bank 0 |
| evt1 | input | 64 | Event bank 1 |
| irq | output | 1 | Channel interrupt |

## Verification
Register effects of a completing descriptor (flag, enable, stopped, address, counters) land on the clock edge that leaves the completion state, so they are readable one cycle later; a wait finishes one cycle after its event line rises, and the memory model answers in the cycle of the request. Rather than counting these cycles from the outside for whole programs, the bench polls the stopped bit at falling edges and only then reads the registers and the sub-unit log, while the wait and ignored-write cases sample mid-run at a point where the engine is provably parked in its wait state.

// File: rtl/dseq_pkg.sv
// Shared types and field positions for the descriptor channel sequencer.
// Assumes 32-bit descriptors and a 2-bit register select.
package dseq_pkg;
    localparam int DESC_W = 32;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_WAIT  = 3'd2,
        OP_JUMP  = 3'd3,
        OP_LOOP  = 3'd4,
        OP_POLL  = 3'd5,
        OP_BRCH  = 3'd6,
        OP_XFER  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_XFETCH, S_WAIT, S_SUB_GO, S_SUB_WAIT, S_END
    } st_e;

    // descriptor flag positions
    localparam int D_INT  = 3;
    localparam int D_STOP = 4;
    localparam int D_LSEL = 5;
    localparam int D_BANK = 6;

    // configuration bit positions
    localparam int C_EN    = 0;
    localparam int C_STOP  = 2;
    localparam int C_MAN   = 3;
    localparam int C_BERR  = 4;
    localparam int C_FLAG  = 16;
    localparam int C_INTEN = 17;

    // register select codes
    localparam logic [1:0] A_NDA  = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_LOOP = 2'd2;
endpackage

// File: rtl/dseq_evmatch.sv
// Event matcher: selects one event bank and reports whether any line under
// the mask is high. Purely combinational; assumes NB is a power of two.
module dseq_evmatch #(
    parameter int NB = 2,
    parameter int EW = 64,
    localparam int SW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0][EW-1:0] banks,
    input  logic [SW-1:0]         sel,
    input  logic [EW-1:0]         mask,
    output logic                  hit
);
    logic [NB-1:0] bank_hit;

    // per-bank masked OR, one reducer per bank
    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_hit[b] = |(banks[b] & mask);
    end

    assign hit = bank_hit[sel];
endmodule

// File: rtl/dseq_core.sv
// Sequencer core: fetch, decode and dispatch of descriptors.
// Owns the state machine, the current descriptor and the wait mask; the
// address register and counters live in dseq_regs and are updated through
// the one-cycle event outputs below. Assumes memory holds mem_ack/mem_err
// low unless mem_req is high.
module dseq_core
    import dseq_pkg::*;
#(
    parameter int DW = DESC_W,
    parameter int CW = 16,
    parameter int NC = 2,
    localparam int MW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 manual,
    input  logic [NC-1:0][CW-1:0] cnt,
    input  logic [DW-1:0]        nda,
    output logic                 mem_req,
    output logic [DW-1:0]        mem_addr,
    input  logic                 mem_ack,
    input  logic                 mem_err,
    input  logic [DW-1:0]        mem_rdata,
    output logic                 sub_start,
    output logic [2:0]           sub_op,
    output logic [DW-1:0]        sub_desc,
    input  logic                 sub_done,
    input  logic                 wait_hit,
    output logic                 wait_sel,
    output logic [MW-1:0]        wait_mask,
    output logic                 nda_inc,
    output logic                 nda_load,
    output logic [DW-1:0]        nda_val,
    output logic [NC-1:0]        cnt_dec,
    output logic                 fin_int,
    output logic                 fin_halt,
    output logic                 berr_ev,
    output logic                 idle
);
    st_e           state;
    logic [DW-1:0] ir;
    logic          xidx;
    logic [DW-1:0] mask_lo, mask_hi;
    op_e           op;
    logic          lsel;

    assign op   = op_e'(ir[2:0]);
    assign lsel = ir[D_LSEL];

    // state machine and descriptor/mask capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            ir      <= '0;
            xidx    <= 1'b0;
            mask_lo <= '0;
            mask_hi <= '0;
        end else begin
            case (state)
                S_IDLE:   if (enable) state <= S_FETCH;
                S_FETCH: begin
                    if (mem_err) state <= S_IDLE;
                    else if (mem_ack) begin
                        ir    <= mem_rdata;
                        state <= S_DECODE;
                    end
                end
                S_DECODE: begin
                    xidx <= 1'b0;
                    case (op)
                        OP_JUMP, OP_WAIT: state <= S_XFETCH;
                        OP_LOOP: state <= (cnt[lsel] != '0) ? S_XFETCH : S_END;
                        default: state <= S_SUB_GO;
                    endcase
                end
                S_XFETCH: begin
                    if (mem_err) state <= S_IDLE;
                    else if (mem_ack) begin
                        if (op != OP_WAIT) state <= S_END;
                        else if (!xidx) begin
                            mask_lo <= mem_rdata;
                            xidx    <= 1'b1;
                        end else begin
                            mask_hi <= mem_rdata;
                            state   <= S_WAIT;
                        end
                    end
                end
                S_WAIT:     if (wait_hit) state <= S_END;
                S_SUB_GO:   state <= S_SUB_WAIT;
                S_SUB_WAIT: if (sub_done) state <= S_END;
                S_END: state <= (ir[D_STOP] || manual || !enable) ? S_IDLE : S_FETCH;
                default: state <= S_IDLE;
            endcase
        end
    end

    // event pulses toward the register block and port drives
    always_comb begin
        nda_inc  = 1'b0;
        nda_load = 1'b0;
        nda_val  = mem_rdata;
        cnt_dec  = '0;
        case (state)
            S_FETCH:  nda_inc = mem_ack && !mem_err;
            S_DECODE: begin
                if (op == OP_LOOP) begin
                    if (cnt[lsel] != '0) cnt_dec[lsel] = 1'b1;
                    else nda_inc = 1'b1;
                end
            end
            S_XFETCH: begin
                if (mem_ack && !mem_err) begin
                    if (op == OP_WAIT) nda_inc = 1'b1;
                    else nda_load = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign mem_req   = (state == S_FETCH) || (state == S_XFETCH);
    assign mem_addr  = nda;
    assign sub_start = (state == S_SUB_GO);
    assign sub_op    = ir[2:0];
    assign sub_desc  = ir;
    assign wait_sel  = ir[D_BANK];
    assign wait_mask = {mask_hi, mask_lo};
    assign fin_int   = (state == S_END) && ir[D_INT];
    assign fin_halt  = (state == S_END) && (ir[D_STOP] || manual);
    assign berr_ev   = mem_req && mem_err;
    assign idle      = (state == S_IDLE);

    // R2: a pending memory request is held with a stable address
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr)));
    // R3: the start pulse lasts one cycle
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sub_start |=> !sub_start);
    // R6: a wait without a hit stays parked
    p_wait_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !wait_hit) |=> (state == S_WAIT));
    // R8: a stop-marked descriptor returns the engine to idle
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_END && ir[D_STOP]) |=> (state == S_IDLE));
endmodule

// File: rtl/dseq_regs.sv
// Register block: descriptor address, configuration and loop counters.
// Applies software writes first and engine events after them, so engine
// updates win in the same cycle. Address and counter writes are accepted
// only while the channel is stopped.
module dseq_regs
    import dseq_pkg::*;
#(
    parameter int DW = DESC_W,
    parameter int CW = 16,
    parameter int NC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    input  logic                  nda_inc,
    input  logic                  nda_load,
    input  logic [DW-1:0]         nda_val,
    input  logic [NC-1:0]         cnt_dec,
    input  logic                  fin_int,
    input  logic                  fin_halt,
    input  logic                  berr_ev,
    input  logic                  idle,
    output logic [DW-1:0]         nda,
    output logic [NC-1:0][CW-1:0] cnt,
    output logic                  enable,
    output logic                  manual,
    output logic                  irq
);
    logic stopped, berr_f, flag, inten;
    logic wr_cfg, wr_nda, wr_loop;

    assign stopped = idle && !enable;
    assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
    assign wr_nda  = reg_wr && (reg_addr == A_NDA) && stopped;
    assign wr_loop = reg_wr && (reg_addr == A_LOOP) && stopped;

    // configuration bits: software writes, then engine events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            manual <= 1'b0;
            berr_f <= 1'b0;
            flag   <= 1'b0;
            inten  <= 1'b0;
        end else begin
            if (wr_cfg) begin
                enable <= reg_wdata[C_EN];
                manual <= reg_wdata[C_MAN];
                inten  <= reg_wdata[C_INTEN];
                if (reg_wdata[C_BERR]) berr_f <= 1'b0;
                if (reg_wdata[C_FLAG]) flag   <= 1'b0;
            end
            if (fin_int) flag <= 1'b1;
            if (fin_halt) enable <= 1'b0;
            if (berr_ev) begin
                berr_f <= 1'b1;
                enable <= 1'b0;
            end
        end
    end

    // next-descriptor address
    always_ff @(posedge clk) begin
        if (!rst_n) nda <= '0;
        else if (nda_load) nda <= nda_val;
        else if (nda_inc) nda <= nda + DW'(4);
        else if (wr_nda) nda <= reg_wdata;
    end

    // one down-counter per loop slot
    for (genvar i = 0; i < NC; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) cnt[i] <= '0;
            else if (cnt_dec[i]) cnt[i] <= cnt[i] - CW'(1);
            else if (wr_loop) cnt[i] <= reg_wdata[i*CW +: CW];
        end

        // R5: a decrement lowers the counter by exactly one
        p_loop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_dec[i] |=> (cnt[i] == $past(cnt[i]) - CW'(1)));
    end

    // read-back mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_NDA:  reg_rdata = nda;
            A_CFG: begin
                reg_rdata[C_EN]    = enable;
                reg_rdata[C_STOP]  = stopped;
                reg_rdata[C_MAN]   = manual;
                reg_rdata[C_BERR]  = berr_f;
                reg_rdata[C_FLAG]  = flag;
                reg_rdata[C_INTEN] = inten;
            end
            A_LOOP: reg_rdata = DW'(cnt);
            default: reg_rdata = '0;
        endcase
    end

    assign irq = flag && inten;

    // R7: the flag persists until software writes 1 to it
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_cfg && reg_wdata[C_FLAG])) |=> flag);
    // R8: a halting completion leaves enable clear
    p_halt_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin_halt |=> !enable);
    // R10: a bus error is recorded and disables the channel
    p_berr_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        berr_ev |=> (berr_f && !enable));
endmodule

// File: rtl/desc_seq.sv
// Top of the descriptor channel sequencer: ties the core, register block
// and event matcher together. Assumes a single clock and that the memory
// port answers each request with exactly one of mem_ack or mem_err.
module desc_seq
    import dseq_pkg::*;
#(
    parameter int DW = DESC_W,
    parameter int CW = 16,
    parameter int NC = 2,
    localparam int MW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [DW-1:0] mem_rdata,
    output logic          sub_start,
    output logic [2:0]    sub_op,
    output logic [DW-1:0] sub_desc,
    input  logic          sub_done,
    input  logic [MW-1:0] evt0,
    input  logic [MW-1:0] evt1,
    output logic          irq
);
    logic                  enable, manual, idle;
    logic [NC-1:0][CW-1:0] cnt;
    logic [DW-1:0]         nda, nda_val;
    logic                  nda_inc, nda_load, fin_int, fin_halt, berr_ev;
    logic [NC-1:0]         cnt_dec;
    logic                  wait_hit, wait_sel;
    logic [MW-1:0]         wait_mask;
    logic [1:0][MW-1:0]    banks;

    assign banks = {evt1, evt0};

    dseq_core #(.DW(DW), .CW(CW), .NC(NC)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .manual(manual),
        .cnt(cnt), .nda(nda),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata),
        .sub_start(sub_start), .sub_op(sub_op), .sub_desc(sub_desc),
        .sub_done(sub_done),
        .wait_hit(wait_hit), .wait_sel(wait_sel), .wait_mask(wait_mask),
        .nda_inc(nda_inc), .nda_load(nda_load), .nda_val(nda_val),
        .cnt_dec(cnt_dec), .fin_int(fin_int), .fin_halt(fin_halt),
        .berr_ev(berr_ev), .idle(idle)
    );

    dseq_regs #(.DW(DW), .CW(CW), .NC(NC)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nda_inc(nda_inc), .nda_load(nda_load), .nda_val(nda_val),
        .cnt_dec(cnt_dec), .fin_int(fin_int), .fin_halt(fin_halt),
        .berr_ev(berr_ev), .idle(idle),
        .nda(nda), .cnt(cnt), .enable(enable), .manual(manual), .irq(irq)
    );

    dseq_evmatch #(.NB(2), .EW(MW)) u_evm (
        .banks(banks), .sel(wait_sel), .mask(wait_mask), .hit(wait_hit)
    );
endmodule

// File: tb/sim_desc_seq.sv
// Bench: memory model answering in the request cycle (addresses >= 0x100
// answer with an error), a sub-unit model that finishes 3 cycles after
// start, an opcode vector table, then directed tests.
module sim_desc_seq;
    localparam int CLK_P = 10;
    localparam int NV = 5;
    localparam logic [31:0] VDESC [NV] = '{32'hA500_0010, 32'h0000_0011,
        32'h1234_0015, 32'h0000_0016, 32'hFF00_0017};
    localparam logic [2:0]  VOP [NV] = '{3'd0, 3'd1, 3'd5, 3'd6, 3'd7};

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mem_req, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_rdata;
    logic sub_start, sub_done;
    logic [2:0] sub_op;
    logic [31:0] sub_desc;
    logic [63:0] evt0 = 0, evt1 = 0;
    logic irq;

    logic [31:0] mem [64];
    int n_chk = 0, n_bad = 0;
    int sub_cnt = 0, n_start = 0;
    logic [2:0] last_op = 0;
    logic [31:0] last_desc = 0;

    always #(CLK_P/2) clk = ~clk;

    desc_seq u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .sub_start(sub_start), .sub_op(sub_op),
        .sub_desc(sub_desc), .sub_done(sub_done), .evt0(evt0), .evt1(evt1),
        .irq(irq));

    assign mem_ack   = mem_req && (mem_addr < 32'h100);
    assign mem_err   = mem_req && (mem_addr >= 32'h100);
    assign mem_rdata = mem[mem_addr[7:2]];
    assign sub_done  = (sub_cnt == 1);

    // sub-unit model and start log
    always @(posedge clk) begin
        if (!rst_n) sub_cnt <= 0;
        else if (sub_start) begin
            sub_cnt   <= 3;
            last_op   <= sub_op;
            last_desc <= sub_desc;
            n_start   <= n_start + 1;
        end else if (sub_cnt != 0) sub_cnt <= sub_cnt - 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] c;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd1, c);
            if (c[2]) break;
        end
    endtask

    task automatic clr_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0000_0010;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s0;
        clr_mem();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(2'd1, v); chk(v == 32'h4, "R1 cfg", v, 32'h4);
        rd(2'd0, v); chk(v == 0, "R1 nda", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 loop", v, 0);
        chk(!irq && !mem_req && !sub_start, "R1 outputs", {irq, mem_req, sub_start}, 0);

        // R2/R3/R8 opcode table: one stop-marked sub-unit descriptor each
        for (int k = 0; k < NV; k++) begin
            clr_mem(); mem[0] = VDESC[k];
            s0 = n_start;
            wr(2'd0, 32'h0); wr(2'd1, 32'h1); wait_stop();
            chk(n_start == s0 + 1, "R3 start count", n_start, s0 + 1);
            chk(last_op == VOP[k], "R3 sub_op", {29'd0, last_op}, {29'd0, VOP[k]});
            chk(last_desc == VDESC[k], "R3 sub_desc", last_desc, VDESC[k]);
            rd(2'd0, v); chk(v == 32'h4, "R2 address advance", v, 32'h4);
            rd(2'd1, v); chk(v == 32'h4, "R8 halted cfg", v, 32'h4);
        end

        // R4 jump to 0x40, run a stop-marked move there
        clr_mem(); mem[0] = 32'h3; mem[1] = 32'h40; mem[16] = 32'h10;
        s0 = n_start;
        wr(2'd0, 0); wr(2'd1, 1); wait_stop();
        rd(2'd0, v); chk(v == 32'h44, "R4 jump target", v, 32'h44);
        chk(n_start == s0 + 1, "R4 one move after jump", n_start, s0 + 1);

        // R5 loop on counter 1 (=2) back to 0: move runs 3 times + final
        clr_mem(); mem[0] = 32'h0; mem[1] = 32'h24; mem[2] = 32'h0; mem[3] = 32'h10;
        s0 = n_start;
        wr(2'd2, 32'h0002_0005); wr(2'd0, 0); wr(2'd1, 1); wait_stop();
        chk(n_start == s0 + 4, "R5 loop iterations", n_start, s0 + 4);
        rd(2'd2, v); chk(v == 32'h0000_0005, "R5 counters", v, 32'h5);
        rd(2'd0, v); chk(v == 32'h10, "R5 skip target word", v, 32'h10);

        // R6 wait on bank 1 with masks lo=0x100 hi=0x8000_0000
        clr_mem(); mem[0] = 32'h52; mem[1] = 32'h100; mem[2] = 32'h8000_0000;
        evt0 = '1; evt1 = 64'h0000_0001_0000_0000;
        wr(2'd0, 0); wr(2'd1, 1);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk(v == 32'h1, "R6 still waiting", v, 32'h1);
        evt1 = 64'h8000_0000_0000_0000;
        wait_stop();
        rd(2'd0, v); chk(v == 32'hC, "R6 wait done", v, 32'hC);
        evt0 = 0; evt1 = 0;

        // R11 writes ignored while parked in a bank-0 wait
        clr_mem(); mem[0] = 32'h12; mem[1] = 32'h1; mem[2] = 32'h0;
        wr(2'd0, 0); wr(2'd1, 1);
        repeat (10) @(negedge clk);
        wr(2'd0, 32'h80); wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd0, v); chk(v == 32'hC, "R11 address write ignored", v, 32'hC);
        rd(2'd2, v); chk(v == 32'h5, "R11 loop write ignored", v, 32'h5);
        evt0 = 64'h1; wait_stop(); evt0 = 0;
        rd(2'd0, v); chk(v == 32'hC, "R11 run finished", v, 32'hC);

        // R7 interrupt flag, irq and write-1 clear
        clr_mem(); mem[0] = 32'h18;
        wr(2'd0, 0); wr(2'd1, 32'h2_0001); wait_stop();
        rd(2'd1, v); chk(v == 32'h3_0004, "R7 flag set", v, 32'h3_0004);
        chk(irq == 1'b1, "R7 irq high", {31'd0, irq}, 1);
        wr(2'd1, 32'h3_0000);
        rd(2'd1, v); chk(v == 32'h2_0004, "R7 flag cleared", v, 32'h2_0004);
        chk(irq == 1'b0, "R7 irq low", {31'd0, irq}, 0);
        wr(2'd1, 32'h0);

        // R9 manual single step
        clr_mem(); mem[0] = 32'h0; mem[1] = 32'h0;
        s0 = n_start;
        wr(2'd0, 0); wr(2'd1, 32'h9); wait_stop();
        rd(2'd0, v); chk(v == 32'h4, "R9 one step", v, 32'h4);
        rd(2'd1, v); chk(v == 32'hC, "R9 halted manual", v, 32'hC);
        wr(2'd1, 32'h9); wait_stop();
        rd(2'd0, v); chk(v == 32'h8, "R9 second step", v, 32'h8);
        chk(n_start == s0 + 2, "R9 two moves", n_start, s0 + 2);
        wr(2'd1, 32'h0);

        // R10 bus error on fetch from 0x100
        wr(2'd0, 32'h100); wr(2'd1, 1); wait_stop();
        rd(2'd1, v); chk(v == 32'h14, "R10 error captured", v, 32'h14);
        wr(2'd1, 32'h10);
        rd(2'd1, v); chk(v == 32'h4, "R10 error cleared", v, 32'h4);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule